// File: doc/BRIEF.md
# Valid-Gated Change Flag Generator

This block drives the sending side of a bus made of a valid strobe, a data word and a change flag. Each clock it takes a raw word and a valid strobe, and one cycle later it presents them as a registered beat. With each beat it presents a flag that tells the receiver whether the word differs from the word of the most recent earlier valid beat. When the flag is low, the receiver can keep using the copy it already holds.

The comparison is made against a reference register that holds the last valid word. Idle cycles (valid low) do not touch that register, so a gap of any length between two beats is skipped. After reset no reference exists, so the first beat always carries a raised flag. Idle cycles drive zero on the data and flag outputs.

The stream has no ready signal and no back-pressure. The sink must accept every beat in the cycle it appears, and the source cannot be stalled. The width of the data word is a parameter, and so is the lane width used to split the comparison.

Top module: `chg_flag_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_new` and `out_data` are zero after that edge, and the reference is cleared.
- R2: `out_valid` after a rising edge equals `in_valid` sampled at that edge (one cycle of latency).
- R3: On a beat (`out_valid` high), `out_data` equals `in_data` sampled at the previous edge.
- R4: When `out_valid` is low, `out_data` is all zeros and `out_new` is 0.
- R5: The first beat after reset has `out_new` = 1, whatever its word.
- R6: On any later beat, `out_new` is 1 exactly when `out_data` differs in at least one bit from the word of the previous beat.
- R7: Idle cycles of any number, including none, between two beats leave the reference unchanged. The comparison therefore skips over the gap.
- R8: On a beat with `out_new` = 0, `out_data` equals the word of the previous beat, so a receiver may keep its held copy.
- R9: A reset in the middle of a stream clears the reference. A beat after it is flagged even if it repeats the word sent before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Raw valid strobe |
| in_data | input | DATA_W | Raw data word |
| out_valid | output | 1 | Registered valid strobe |
| out_data | output | DATA_W | Registered word, zero when idle |
| out_new | output | 1 | Word differs from the previous beat's word |

## Verification
Every output is due one rising edge after the inputs that cause it. This includes the flag, which is computed from the held reference at that same edge. The bench drives inputs on the falling edge and updates its model for the coming rising edge. It compares all three outputs at the next falling edge, half a period after they settle. The model holds the last beat's word independently of the design. Gap lengths from zero upward are exercised, and so is a reset issued between two identical words.

// File: rtl/chg_pkg.sv
package chg_pkg;
  // Whether a comparison reference exists since the last reset.
  typedef enum logic {
    REF_EMPTY = 1'b0,
    REF_HELD  = 1'b1
  } ref_state_t;
endpackage

// File: rtl/chg_ref_hold.sv
module chg_ref_hold
  import chg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] ref_word,
  output ref_state_t   ref_state
);
  // Loads only on valid beats; idle cycles leave it untouched.
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_word  <= '0;
      ref_state <= REF_EMPTY;
    end else if (load) begin
      ref_word  <= load_data;
      ref_state <= REF_HELD;
    end
  end
endmodule

// File: rtl/chg_compare.sv
module chg_compare #(
  parameter int W      = 8,
  parameter int LANE_W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         differ
);
  localparam int NUM_LANES = (W + LANE_W - 1) / LANE_W;
  localparam int PAD_W     = NUM_LANES * LANE_W;

  logic [PAD_W-1:0]     pa, pb;
  logic [NUM_LANES-1:0] lane_diff;

  always_comb begin
    pa = '0;
    pb = '0;
    pa[W-1:0] = a;
    pb[W-1:0] = b;
  end

  // Per-lane inequality, then one OR across lanes.
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_diff[i] = |(pa[i*LANE_W +: LANE_W] ^ pb[i*LANE_W +: LANE_W]);
  end

  assign differ = |lane_diff;
endmodule

// File: rtl/chg_out_stage.sv
module chg_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         beat_valid,
  input  logic [W-1:0] beat_data,
  input  logic         beat_new,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_new
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_new   <= 1'b0;
    end else begin
      out_valid <= beat_valid;
      out_data  <= beat_valid ? beat_data : '0;
      out_new   <= beat_valid & beat_new;
    end
  end
endmodule

// File: rtl/chg_flag_gen.sv
module chg_flag_gen
  import chg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_new
);
  logic [DATA_W-1:0] ref_word;
  ref_state_t        ref_state;
  logic              word_differs;
  logic              flag_next;

  chg_ref_hold #(.W(DATA_W)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .load      (in_valid),
    .load_data (in_data),
    .ref_word  (ref_word),
    .ref_state (ref_state)
  );

  chg_compare #(.W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .a      (in_data),
    .b      (ref_word),
    .differ (word_differs)
  );

  // With no reference yet, the beat is always reported as new.
  assign flag_next = (ref_state == REF_EMPTY) | word_differs;

  chg_out_stage #(.W(DATA_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .beat_valid (in_valid),
    .beat_data  (in_data),
    .beat_new   (flag_next),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_new    (out_new)
  );
endmodule

// File: rtl/chg_flag_gen_chk.sv
module chg_flag_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_new
);
  // Observer copy of the previous beat's word, built from the outputs only.
  logic [W-1:0] seen_word;
  logic         seen_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_word <= '0;
      seen_any  <= 1'b0;
    end else if (out_valid) begin
      seen_word <= out_data;
      seen_any  <= 1'b1;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r3_data_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_data == $past(in_data)));
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_data == '0 && !out_new));
  a_r5_first_flagged: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !seen_any) |-> out_new);
  a_r6_flag_matches_change: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_any) |-> (out_new == (out_data != seen_word)));
  a_r8_hold_safe: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_new) |-> (seen_any && out_data == seen_word));
endmodule

bind chg_flag_gen chg_flag_gen_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_new   (out_new)
);

// File: tb/test_chg_flag_gen.sv
`timescale 1ns/1ps
module test_chg_flag_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_new;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // Behavioural model state
  bit           m_has_ref = 0;
  int           m_ref     = 0;
  int           m_gap     = 0;
  bit           e_valid, e_new;
  int           e_data;

  always #2.5 clk = ~clk;

  chg_flag_gen #(.DATA_W(W), .LANE_W(3)) i_chg_flag_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_new(out_new)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one cycle; r = reset, v/d = inputs.
  task automatic step(input bit r, input bit v, input int d);
    string tag;
    @(negedge clk);
    rst = r; in_valid = v; in_data = W'(d);
    if (r) begin
      e_valid = 0; e_data = 0; e_new = 0;
      m_has_ref = 0; m_gap = 0;
      tag = "R1/R9";
    end else if (!v) begin
      e_valid = 0; e_data = 0; e_new = 0;
      m_gap++;
      tag = "R4";
    end else begin
      e_valid = 1; e_data = d & ((1 << W) - 1);
      if (!m_has_ref) begin e_new = 1; tag = "R5"; end
      else begin
        e_new = (e_data != m_ref);
        tag = (m_gap > 0) ? "R7" : "R6";
      end
      // R8: a low flag lets the receiver keep the previous word
      if (m_has_ref && !e_new && e_data != m_ref) begin
        fails++; $display("FAIL R8: model inconsistency");
      end
      m_ref = e_data; m_has_ref = 1; m_gap = 0;
    end
    @(negedge clk);
    check({"R2 valid ", tag}, out_valid, e_valid);
    check({"R3 data ",  tag}, out_data,  e_data);
    check({"flag ",     tag}, out_new,   e_new);
    if (e_valid && !e_new) check("R8 hold", out_data, m_ref);
  endtask

  initial begin
    step(1, 0, 0);
    step(1, 1, 8'h55);              // R1: reset dominates valid
    step(0, 0, 0);                  // R4 idle
    step(0, 1, 8'h00);              // R5 first beat, zero word, still flagged
    step(0, 1, 8'h00);              // R6 same, no gap
    step(0, 1, 8'h01);              // R6 changed
    step(0, 0, 8'hAA);              // R4 idle ignores data
    step(0, 0, 8'hBB);
    step(0, 1, 8'h01);              // R7 same across gap
    for (int k = 0; k < 7; k++) step(0, 0, k);
    step(0, 1, 8'h80);              // R7 change across long gap
    step(0, 1, 8'h80);              // R8 hold
    step(1, 0, 0);                  // R9 reset mid-stream
    step(0, 1, 8'h80);              // R9 repeated word flagged
    step(0, 1, 8'hFF);
    step(0, 1, 8'h7F);              // top bit lane only
    for (int k = 0; k < 2000; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) step(0, 0, $urandom);
      else if (sel < 4) step(0, 1, m_ref);
      else if (sel < 8) step(0, 1, $urandom_range(0, 3));
      else if (sel == 8) step(0, $urandom_range(0, 1), $urandom);
      else step((k % 97) == 0, 1, $urandom);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule